// File: doc/BRIEF.md
# Static Heuristic Branch Direction Predictor

This block predicts the direction and destination of a branch when no learned history is available, for example on a cold start or in a front end that has no dynamic tables. The fetch/decode logic presents one branch per cycle. Each request carries an already decoded opcode class, the branch address, the signed word offset from the instruction and a compiler-provided hint bit. A two-bit policy input picks one of four fixed heuristics. One clock later the block returns a registered taken/not-taken decision and the computed destination address.

The four policies are: predict every conditional branch not taken; predict by offset direction, so a backward branch is taken and a forward branch is not; use per-class rules for sign-comparing branches, where a less-than-zero style test is expected to fail and a greater-than-zero style test is expected to succeed; and follow the compiler's hint bit. An unconditional jump is taken under every policy. The destination is computed for every request, whatever the decision.

Top module: `static_hint_predictor`

## Requirements
- R1: While reset is asserted, and until the first request after reset, `pred_valid` and `pred_taken` are 0 and `pred_target` is 0.
- R2: `pred_valid` equals the `req_valid` of the previous cycle. In a cycle without a request, `pred_taken` and `pred_target` keep their last values.
- R3: With `policy` = 0 (static not-taken), every branch of class other than 5 is predicted not taken.
- R4: With `policy` = 1 (offset direction), a branch of class other than 5 is predicted taken exactly when the offset's top bit is 1, that is, when the offset is negative.
- R5: With `policy` = 2 (class rules), class 1 (branch if less than zero) and class 2 (branch if less than or equal to zero) are predicted not taken.
- R6: With `policy` = 2, class 3 (branch if greater than zero) and class 4 (branch if greater than or equal to zero) are predicted taken.
- R7: With `policy` = 2, class 0 (equality compare) and the unused codes 6 and 7 are predicted by offset direction, as in R4.
- R8: With `policy` = 3 (compiler hint), a branch of class other than 5 is predicted taken when `hint_bit` is 1 and not taken when it is 0.
- R9: Class 5 (unconditional jump) is predicted taken under every policy.
- R10: `pred_target` equals `br_pc + 4 + (sign-extended br_offset shifted left by 2)`, modulo 2^32. It is computed for every request, whatever the predicted direction.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| req_valid | input | 1 | A branch is presented this cycle |
| br_class | input | 3 | Decoded branch class (0 eq, 1 ltz, 2 lez, 3 gtz, 4 gez, 5 jump) |
| policy | input | 2 | Heuristic select (0 not-taken, 1 offset direction, 2 class rules, 3 hint) |
| br_pc | input | 32 | Address of the branch instruction |
| br_offset | input | 16 | Signed word offset of the branch |
| hint_bit | input | 1 | Compiler hint, 1 for likely taken |
| pred_valid | output | 1 | Registered prediction is valid |
| pred_taken | output | 1 | Predicted direction, 1 for taken |
| pred_target | output | 32 | Predicted destination address |

## Verification
The hardest case to reach is a disagreement between two heuristics that matter at once. Examples are a sign-comparing class whose offset sign points the other way from its class rule, a jump whose hint bit says not taken, and an equality branch under the class-rule policy that has to fall back to the offset. The stimulus sweeps every policy against every class code, including the unused ones, with both offset signs and both hint values, so that each conflict happens. Further requests use an address near the top of the range and the most negative offset, which drive the destination adder through wrap-around. An idle gap checks that the outputs hold their values.

// File: rtl/sph_pkg.sv
package sph_pkg;
  localparam int unsigned CLS_W  = 3;
  localparam int unsigned POL_W  = 2;

  localparam logic [CLS_W-1:0] CLS_EQ  = 3'd0;
  localparam logic [CLS_W-1:0] CLS_LTZ = 3'd1;
  localparam logic [CLS_W-1:0] CLS_LEZ = 3'd2;
  localparam logic [CLS_W-1:0] CLS_GTZ = 3'd3;
  localparam logic [CLS_W-1:0] CLS_GEZ = 3'd4;
  localparam logic [CLS_W-1:0] CLS_JMP = 3'd5;

  typedef enum logic [POL_W-1:0] {
    POL_NEVER = 2'd0,
    POL_DIR   = 2'd1,
    POL_RULES = 2'd2,
    POL_HINT  = 2'd3
  } policy_e;
endpackage

// File: rtl/sph_dir_sel.sv
module sph_dir_sel
  import sph_pkg::*;
(
  input  logic [CLS_W-1:0] cls_i,
  input  logic [POL_W-1:0] policy_i,
  input  logic             backward_i,
  input  logic             hint_i,
  output logic             taken_o
);
  logic rule_dir;

  // class rules: sign tests get a fixed direction, the rest use the offset
  always_comb begin
    case (cls_i)
      CLS_LTZ, CLS_LEZ: rule_dir = 1'b0;
      CLS_GTZ, CLS_GEZ: rule_dir = 1'b1;
      default:          rule_dir = backward_i;
    endcase
  end

  always_comb begin
    case (policy_e'(policy_i))
      POL_NEVER: taken_o = 1'b0;
      POL_DIR:   taken_o = backward_i;
      POL_RULES: taken_o = rule_dir;
      POL_HINT:  taken_o = hint_i;
      default:   taken_o = 1'b0;
    endcase
    if (cls_i == CLS_JMP) taken_o = 1'b1;
  end
endmodule

// File: rtl/sph_target_calc.sv
module sph_target_calc #(
  parameter int unsigned PC_W  = 32,
  parameter int unsigned OFF_W = 16,
  parameter int unsigned SHIFT = 2,
  parameter int unsigned STEP  = 4
) (
  input  logic [PC_W-1:0]  pc_i,
  input  logic [OFF_W-1:0] off_i,
  output logic [PC_W-1:0]  target_o
);
  localparam int unsigned EXT_W = PC_W - OFF_W;

  logic [PC_W-1:0] off_ext;
  logic [PC_W-1:0] seq_pc;

  generate
    if (EXT_W > 0) begin : g_ext
      assign off_ext = {{EXT_W{off_i[OFF_W-1]}}, off_i};
    end else begin : g_trunc
      assign off_ext = off_i[PC_W-1:0];
    end
  endgenerate

  assign seq_pc   = pc_i + PC_W'(STEP);
  assign target_o = seq_pc + (off_ext << SHIFT);
endmodule

// File: rtl/sph_out_reg.sv
module sph_out_reg #(
  parameter int unsigned PC_W = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cap_en,
  input  logic            taken_i,
  input  logic [PC_W-1:0] target_i,
  output logic            valid_o,
  output logic            taken_o,
  output logic [PC_W-1:0] target_o
);
  logic            valid_n;
  logic            taken_n;
  logic [PC_W-1:0] target_n;

  always_comb begin
    valid_n  = cap_en;
    taken_n  = taken_o;
    target_n = target_o;
    if (cap_en) begin
      taken_n  = taken_i;
      target_n = target_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_o  <= 1'b0;
      taken_o  <= 1'b0;
      target_o <= '0;
    end else begin
      valid_o  <= valid_n;
      taken_o  <= taken_n;
      target_o <= target_n;
    end
  end

  // R2
  hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cap_en |=> ($stable(taken_o) && $stable(target_o)));
endmodule

// File: rtl/static_hint_predictor.sv
module static_hint_predictor
  import sph_pkg::*;
#(
  parameter int unsigned PC_W  = 32,
  parameter int unsigned OFF_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [2:0]       br_class,
  input  logic [1:0]       policy,
  input  logic [PC_W-1:0]  br_pc,
  input  logic [OFF_W-1:0] br_offset,
  input  logic             hint_bit,
  output logic             pred_valid,
  output logic             pred_taken,
  output logic [PC_W-1:0]  pred_target
);
  localparam int unsigned WORD_SHIFT = 2;
  localparam int unsigned INSN_BYTES = 4;

  logic            rst_meta;
  logic            rst_sync_n;
  logic            dir_taken;
  logic [PC_W-1:0] calc_target;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta   <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta   <= 1'b1;
      rst_sync_n <= rst_meta;
    end
  end

  sph_dir_sel u_dir (
    .cls_i      (br_class),
    .policy_i   (policy),
    .backward_i (br_offset[OFF_W-1]),
    .hint_i     (hint_bit),
    .taken_o    (dir_taken)
  );

  sph_target_calc #(
    .PC_W  (PC_W),
    .OFF_W (OFF_W),
    .SHIFT (WORD_SHIFT),
    .STEP  (INSN_BYTES)
  ) u_tgt (
    .pc_i     (br_pc),
    .off_i    (br_offset),
    .target_o (calc_target)
  );

  sph_out_reg #(.PC_W(PC_W)) u_out (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .cap_en   (req_valid),
    .taken_i  (dir_taken),
    .target_i (calc_target),
    .valid_o  (pred_valid),
    .taken_o  (pred_taken),
    .target_o (pred_target)
  );

  // R2
  valid_latency_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    req_valid |=> pred_valid);

  // R9
  jump_taken_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (req_valid && br_class == CLS_JMP) |=> pred_taken);

  // R3
  never_policy_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (req_valid && policy == POL_NEVER && br_class != CLS_JMP) |=> !pred_taken);

  // R4
  dir_policy_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (req_valid && policy == POL_DIR && br_class != CLS_JMP)
      |=> (pred_taken == $past(br_offset[OFF_W-1])));

  // R5
  neg_test_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (req_valid && policy == POL_RULES && (br_class == CLS_LTZ || br_class == CLS_LEZ))
      |=> !pred_taken);

  // R6
  pos_test_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (req_valid && policy == POL_RULES && (br_class == CLS_GTZ || br_class == CLS_GEZ))
      |=> pred_taken);

  // R8
  hint_policy_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (req_valid && policy == POL_HINT && br_class != CLS_JMP)
      |=> (pred_taken == $past(hint_bit)));
endmodule

// File: tb/static_hint_predictor_tb_top.sv
module static_hint_predictor_tb_top;
  localparam int CLK_PERIOD = 10;

  typedef struct {
    logic        taken;
    logic [31:0] target;
    string       dtag;
  } exp_t;

  logic        clk;
  logic        rst_n;
  logic        req_valid;
  logic [2:0]  br_class;
  logic [1:0]  policy;
  logic [31:0] br_pc;
  logic [15:0] br_offset;
  logic        hint_bit;
  logic        pred_valid;
  logic        pred_taken;
  logic [31:0] pred_target;

  exp_t        sb_q[$];
  int          checks;
  int          errors;
  logic        last_taken;
  logic [31:0] last_target;

  static_hint_predictor dut_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .br_class    (br_class),
    .policy      (policy),
    .br_pc       (br_pc),
    .br_offset   (br_offset),
    .hint_bit    (hint_bit),
    .pred_valid  (pred_valid),
    .pred_taken  (pred_taken),
    .pred_target (pred_target)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic model_dir(input logic [2:0] c, input logic [1:0] p,
                                     input logic [15:0] o, input logic h);
    if (c == 3'd5) return 1'b1;                  // R9
    case (p)
      2'd0: return 1'b0;                         // R3
      2'd1: return o[15];                        // R4
      2'd2: begin
        if (c == 3'd1 || c == 3'd2) return 1'b0; // R5
        if (c == 3'd3 || c == 3'd4) return 1'b1; // R6
        return o[15];                            // R7
      end
      default: return h;                         // R8
    endcase
  endfunction

  function automatic string dir_tag(input logic [2:0] c, input logic [1:0] p);
    if (c == 3'd5) return "R9";
    case (p)
      2'd0: return "R3";
      2'd1: return "R4";
      2'd2: return (c >= 3'd1 && c <= 3'd4) ? ((c <= 3'd2) ? "R5" : "R6") : "R7";
      default: return "R8";
    endcase
  endfunction

  task automatic send(input logic [2:0] c, input logic [1:0] p, input logic [31:0] pc,
                      input logic [15:0] o, input logic h);
    exp_t e;
    @(negedge clk);
    req_valid = 1'b1;
    br_class  = c;
    policy    = p;
    br_pc     = pc;
    br_offset = o;
    hint_bit  = h;
    e.taken   = model_dir(c, p, o, h);
    e.target  = pc + 32'd4 + ({{16{o[15]}}, o} << 2);   // R10
    e.dtag    = dir_tag(c, p);
    sb_q.push_back(e);
    last_taken  = e.taken;
    last_target = e.target;
  endtask

  task automatic go_idle();
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  // monitor: compares each produced prediction with the oldest expected item
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (rst_n && pred_valid) begin
        if (sb_q.size() == 0) begin
          check(1'b0, "R2 unexpected valid", {31'd0, pred_valid}, 32'd0);
        end else begin
          exp_t e;
          e = sb_q.pop_front();
          check(pred_taken == e.taken, e.dtag, {31'd0, pred_taken}, {31'd0, e.taken});
          check(pred_target == e.target, "R10", pred_target, e.target);
        end
      end
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=%h expected=%h", 32'd1, 32'd0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    checks = 0;
    errors = 0;
    rst_n = 1'b0;
    req_valid = 1'b0;
    br_class = 3'd0;
    policy = 2'd0;
    br_pc = 32'd0;
    br_offset = 16'd0;
    hint_bit = 1'b0;
    repeat (3) @(negedge clk);
    // R1: state during reset
    check(pred_valid == 1'b0, "R1", {31'd0, pred_valid}, 32'd0);
    check(pred_taken == 1'b0, "R1", {31'd0, pred_taken}, 32'd0);
    check(pred_target == 32'd0, "R1", pred_target, 32'd0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    // R1: still clear after release with no request
    check(pred_valid == 1'b0, "R1", {31'd0, pred_valid}, 32'd0);
    check(pred_target == 32'd0, "R1", pred_target, 32'd0);

    // sweep every policy x class code x offset sign x hint (R3..R9)
    for (int p = 0; p < 4; p++) begin
      for (int c = 0; c < 8; c++) begin
        for (int s = 0; s < 2; s++) begin
          for (int h = 0; h < 2; h++) begin
            send(3'(c), 2'(p), 32'h0000_4000 + 32'(c * 64),
                 (s != 0) ? 16'hFFF6 : 16'h000C, 1'(h));
          end
        end
      end
      go_idle();
    end

    // R10 boundaries: wrap past the top, most negative and most positive offsets
    send(3'd0, 2'd0, 32'hFFFF_FFFC, 16'h0000, 1'b0);
    send(3'd5, 2'd1, 32'hFFFF_FFF0, 16'h0010, 1'b0);
    send(3'd3, 2'd2, 32'h0000_0100, 16'h8000, 1'b0);
    send(3'd1, 2'd3, 32'h0000_0000, 16'h7FFF, 1'b1);
    send(3'd6, 2'd2, 32'h0000_0000, 16'hFFFF, 1'b0);

    // R2: idle gap keeps the last prediction and drops valid
    go_idle();
    repeat (3) @(negedge clk);
    check(pred_valid == 1'b0, "R2", {31'd0, pred_valid}, 32'd0);
    check(pred_taken == last_taken, "R2", {31'd0, pred_taken}, {31'd0, last_taken});
    check(pred_target == last_target, "R2", pred_target, last_target);
    check(sb_q.size() == 0, "R2 missing predictions", 32'(sb_q.size()), 32'd0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule